// File: doc/BRIEF.md
# Lockstep Lane Divergence Sequencer

This block steers the control flow of one packet of lanes that run in lockstep on a single shared instruction pointer. Each cycle it may receive one decoded control event: a plain instruction step, a conditional branch with a per-lane condition vector, or a return. It holds the active-lane mask and a small stack of deferred paths. From these it produces the instruction pointer for the next fetch, the lanes allowed to commit results, and a one-cycle completion pulse when the packet has nothing left to run.

When the active lanes disagree on a branch, the lanes that take the branch run first under their own mask. The fall-through address and the mask of the remaining lanes are saved on the stack. A return does not go back to a caller. It resumes the most recently deferred path, so divergent paths run one after another and never at the same time. A start pulse loads a fresh packet. With four lanes the stack never holds more than three entries. The depth is a parameter, and a push that finds the stack full is dropped and flagged.

Top module: `lane_div_seq`

## Requirements
- R1: A start pulse loads the instruction pointer from `start_ip_i`, sets every mask bit to 1, empties the deferred-path stack and clears the overflow flag. Start wins over every other event in the same cycle.
- R2: A step event with at least one lane active advances the instruction pointer by one and leaves the mask unchanged.
- R3: A branch where every active lane has its condition bit set jumps to `br_target_i`, keeps the mask and pushes nothing. Condition bits of inactive lanes are ignored.
- R4: A branch where no active lane has its condition bit set advances the instruction pointer by one, keeps the mask and pushes nothing.
- R5: A branch where only some active lanes have their condition bit set jumps to `br_target_i` with the mask reduced to those lanes. It pushes the address after the branch together with the mask of the other active lanes.
- R6: A return with a non-empty stack pops the newest entry and continues from its address under its stored mask, in last-in first-out order.
- R7: A return with an empty stack clears the mask and raises `done_o` for exactly one cycle. While the mask is zero, step, branch and return events have no effect.
- R8: A divergent branch that finds STACK_DEPTH entries already stored still follows the taken lanes but drops the push. It sets `overflow_o`, which stays set until reset or the next start.
- R9: `commit_o` equals the current mask in any cycle that carries a step, branch or return event, and is zero otherwise or when no lane is active.
- R10: When several events arrive in one cycle, return takes precedence over branch, and branch over step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load a new packet |
| start_ip_i | input | IP_W | Entry address of the new packet |
| step_i | input | 1 | Plain instruction executed |
| br_i | input | 1 | Conditional branch executed |
| ret_i | input | 1 | Return executed |
| br_target_i | input | IP_W | Branch destination |
| cond_i | input | LANES | Per-lane branch condition |
| ip_o | output | IP_W | Current instruction pointer |
| mask_o | output | LANES | Current active-lane mask |
| commit_o | output | LANES | Lanes that commit in this cycle |
| done_o | output | 1 | Packet finished, one-cycle pulse |
| overflow_o | output | 1 | Sticky deferred-path stack overflow |

## Verification
`commit_o` is combinational, so it is due in the same cycle as the event that causes it. The bench reads it one time unit after it drives the inputs on the falling edge. The pointer, mask, done pulse and overflow flag are all single registers, updated at the rising edge that samples the event. The bench advances its reference model at that edge and compares these four outputs at the next falling edge, before it drives the next event. Random event streams are run against a stack depth of two, which the lane count can exceed. Directed sequences cover three-deep splits, last-in first-out pops, overflow and idle inputs.

// File: rtl/lds_pkg.sv
package lds_pkg;

   typedef enum logic [1:0] {
      BR_FALL  = 2'd0,
      BR_JUMP  = 2'd1,
      BR_SPLIT = 2'd2
   } br_kind_e;

   typedef enum logic [2:0] {
      EV_IDLE  = 3'd0,
      EV_START = 3'd1,
      EV_RET   = 3'd2,
      EV_BR    = 3'd3,
      EV_STEP  = 3'd4
   } ev_sel_e;

endpackage

// File: rtl/lds_branch_eval.sv
module lds_branch_eval
   import lds_pkg::*;
#(
   parameter int LANES = 4
) (
   input  logic [LANES-1:0] active_i,
   input  logic [LANES-1:0] cond_i,
   output logic [LANES-1:0] taken_o,
   output logic [LANES-1:0] rest_o,
   output br_kind_e         kind_o
);

   logic [LANES-1:0] tk;
   logic [LANES-1:0] rs;

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         assign tk[g] = active_i[g] & cond_i[g];
         assign rs[g] = active_i[g] & ~cond_i[g];
      end
   endgenerate

   always_comb begin
      if (tk == '0) begin
         kind_o = BR_FALL;
      end else if (rs == '0) begin
         kind_o = BR_JUMP;
      end else begin
         kind_o = BR_SPLIT;
      end
   end

   assign taken_o = tk;
   assign rest_o  = rs;

endmodule

// File: rtl/lds_path_stack.sv
module lds_path_stack #(
   parameter int DEPTH = 8,
   parameter int IP_W  = 16,
   parameter int LANES = 4,
   localparam int CNT_W = $clog2(DEPTH + 1),
   localparam int ENT_W = IP_W + LANES
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             push_i,
   input  logic             pop_i,
   input  logic [IP_W-1:0]  push_ip_i,
   input  logic [LANES-1:0] push_mask_i,
   output logic [IP_W-1:0]  top_ip_o,
   output logic [LANES-1:0] top_mask_o,
   output logic             empty_o,
   output logic             full_o,
   output logic [CNT_W-1:0] count_o
);

   logic [CNT_W-1:0] cnt_q;
   logic [ENT_W-1:0] slot_q [DEPTH];
   logic [ENT_W-1:0] top_ent;

   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("lds_path_stack: DEPTH must be at least 1");
      end
      for (genvar s = 0; s < DEPTH; s++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               slot_q[s] <= '0;
            end else if (push_i && !full_o && (cnt_q == CNT_W'(s))) begin
               slot_q[s] <= {push_ip_i, push_mask_i};
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clear_i) begin
         cnt_q <= '0;
      end else if (push_i && !full_o) begin
         cnt_q <= cnt_q + 1'b1;
      end else if (pop_i && !empty_o) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   always_comb begin
      top_ent = '0;
      for (int k = 0; k < DEPTH; k++) begin
         if (cnt_q == CNT_W'(k + 1)) begin
            top_ent = slot_q[k];
         end
      end
   end

   assign top_ip_o   = top_ent[ENT_W-1:LANES];
   assign top_mask_o = top_ent[LANES-1:0];
   assign empty_o    = (cnt_q == '0);
   assign full_o     = (cnt_q == CNT_W'(DEPTH));
   assign count_o    = cnt_q;

endmodule

// File: rtl/lds_event_sel.sv
module lds_event_sel
   import lds_pkg::*;
(
   input  logic    live_i,
   input  logic    start_i,
   input  logic    ret_i,
   input  logic    br_i,
   input  logic    step_i,
   output ev_sel_e sel_o
);

   always_comb begin
      if (start_i) begin
         sel_o = EV_START;
      end else if (!live_i) begin
         sel_o = EV_IDLE;
      end else if (ret_i) begin
         sel_o = EV_RET;
      end else if (br_i) begin
         sel_o = EV_BR;
      end else if (step_i) begin
         sel_o = EV_STEP;
      end else begin
         sel_o = EV_IDLE;
      end
   end

endmodule

// File: rtl/lane_div_seq.sv
module lane_div_seq
   import lds_pkg::*;
#(
   parameter int LANES       = 4,
   parameter int IP_W        = 16,
   parameter int STACK_DEPTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [IP_W-1:0]  start_ip_i,
   input  logic             step_i,
   input  logic             br_i,
   input  logic             ret_i,
   input  logic [IP_W-1:0]  br_target_i,
   input  logic [LANES-1:0] cond_i,
   output logic [IP_W-1:0]  ip_o,
   output logic [LANES-1:0] mask_o,
   output logic [LANES-1:0] commit_o,
   output logic             done_o,
   output logic             overflow_o
);

   localparam int CNT_W = $clog2(STACK_DEPTH + 1);

   generate
      if (LANES < 2) begin : g_bad_lanes
         $error("lane_div_seq: LANES must be at least 2");
      end
      if (IP_W < 1) begin : g_bad_ipw
         $error("lane_div_seq: IP_W must be at least 1");
      end
   endgenerate

   logic [IP_W-1:0]  ip_q, ip_d;
   logic [LANES-1:0] mask_q, mask_d;
   logic             done_q, done_d;
   logic             ovf_q, ovf_d;

   logic             live;
   ev_sel_e          sel;
   br_kind_e         kind;
   logic [LANES-1:0] taken_m, rest_m;
   logic [IP_W-1:0]  ip_inc;

   logic             st_push, st_pop;
   logic [IP_W-1:0]  st_top_ip;
   logic [LANES-1:0] st_top_mask;
   logic             st_empty, st_full;
   logic [CNT_W-1:0] st_count;

   assign live   = |mask_q;
   assign ip_inc = ip_q + 1'b1;

   lds_event_sel u_sel (
      .live_i  (live),
      .start_i (start_i),
      .ret_i   (ret_i),
      .br_i    (br_i),
      .step_i  (step_i),
      .sel_o   (sel)
   );

   lds_branch_eval #(
      .LANES (LANES)
   ) u_eval (
      .active_i (mask_q),
      .cond_i   (cond_i),
      .taken_o  (taken_m),
      .rest_o   (rest_m),
      .kind_o   (kind)
   );

   assign st_push = (sel == EV_BR) && (kind == BR_SPLIT) && !st_full;
   assign st_pop  = (sel == EV_RET) && !st_empty;

   lds_path_stack #(
      .DEPTH (STACK_DEPTH),
      .IP_W  (IP_W),
      .LANES (LANES)
   ) u_stack (
      .clk         (clk),
      .rst_n       (rst_n),
      .clear_i     (sel == EV_START),
      .push_i      (st_push),
      .pop_i       (st_pop),
      .push_ip_i   (ip_inc),
      .push_mask_i (rest_m),
      .top_ip_o    (st_top_ip),
      .top_mask_o  (st_top_mask),
      .empty_o     (st_empty),
      .full_o      (st_full),
      .count_o     (st_count)
   );

   always_comb begin
      ip_d   = ip_q;
      mask_d = mask_q;
      done_d = 1'b0;
      ovf_d  = ovf_q;
      unique case (sel)
         EV_START: begin
            ip_d   = start_ip_i;
            mask_d = '1;
            ovf_d  = 1'b0;
         end
         EV_RET: begin
            if (st_empty) begin
               mask_d = '0;
               done_d = 1'b1;
            end else begin
               ip_d   = st_top_ip;
               mask_d = st_top_mask;
            end
         end
         EV_BR: begin
            unique case (kind)
               BR_FALL:  ip_d = ip_inc;
               BR_JUMP:  ip_d = br_target_i;
               BR_SPLIT: begin
                  ip_d   = br_target_i;
                  mask_d = taken_m;
                  if (st_full) begin
                     ovf_d = 1'b1;
                  end
               end
               default:  ip_d = ip_q;
            endcase
         end
         EV_STEP: begin
            ip_d = ip_inc;
         end
         default: begin
            ip_d = ip_q;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ip_q   <= '0;
         mask_q <= '0;
         done_q <= 1'b0;
         ovf_q  <= 1'b0;
      end else begin
         ip_q   <= ip_d;
         mask_q <= mask_d;
         done_q <= done_d;
         ovf_q  <= ovf_d;
      end
   end

   assign commit_o   = (sel == EV_RET || sel == EV_BR || sel == EV_STEP) ? mask_q : '0;
   assign ip_o       = ip_q;
   assign mask_o     = mask_q;
   assign done_o     = done_q;
   assign overflow_o = ovf_q;

endmodule

// File: rtl/lane_div_seq_chk.sv
module lane_div_seq_chk #(
   parameter int LANES       = 4,
   parameter int IP_W        = 16,
   parameter int STACK_DEPTH = 8,
   localparam int CNT_W = $clog2(STACK_DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic [IP_W-1:0]  start_ip_i,
   input logic             step_i,
   input logic             br_i,
   input logic             ret_i,
   input logic [LANES-1:0] cond_i,
   input logic [IP_W-1:0]  ip_o,
   input logic [LANES-1:0] mask_o,
   input logic [LANES-1:0] commit_o,
   input logic             done_o,
   input logic             overflow_o,
   input logic [CNT_W-1:0] depth
);

   logic [LANES-1:0] act_cond;
   assign act_cond = cond_i & mask_o;

   p_start_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (mask_o == '1) && (ip_o == $past(start_ip_i)) && !overflow_o && (depth == '0));

   p_step_adv_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_i && !ret_i && !br_i && step_i && (|mask_o))
      |=> (ip_o == IP_W'($past(ip_o) + 1'b1)) && (mask_o == $past(mask_o)));

   p_uniform_no_push_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_i && !ret_i && br_i && (|mask_o) && ((act_cond == mask_o) || (act_cond == '0)))
      |=> (depth == $past(depth)) && (mask_o == $past(mask_o)));

   p_split_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_i && !ret_i && br_i && (act_cond != mask_o) && (act_cond != '0))
      |=> (mask_o == $past(act_cond)));

   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (mask_o == '0));

   p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (overflow_o && !start_i) |=> overflow_o);

   p_depth_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      depth <= CNT_W'(STACK_DEPTH));

   p_commit_subset_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_o & ~mask_o) == '0);

endmodule

bind lane_div_seq lane_div_seq_chk #(
   .LANES       (LANES),
   .IP_W        (IP_W),
   .STACK_DEPTH (STACK_DEPTH)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .start_ip_i (start_ip_i),
   .step_i     (step_i),
   .br_i       (br_i),
   .ret_i      (ret_i),
   .cond_i     (cond_i),
   .ip_o       (ip_o),
   .mask_o     (mask_o),
   .commit_o   (commit_o),
   .done_o     (done_o),
   .overflow_o (overflow_o),
   .depth      (st_count)
);

// File: tb/lane_div_seq_test.sv
module lane_div_seq_test;

   localparam int CLK_PERIOD = 10;
   localparam int LANES      = 4;
   localparam int IP_W       = 16;
   localparam int DEPTH      = 2;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start_i = 1'b0;
   logic [IP_W-1:0]  start_ip_i = '0;
   logic             step_i = 1'b0;
   logic             br_i = 1'b0;
   logic             ret_i = 1'b0;
   logic [IP_W-1:0]  br_target_i = '0;
   logic [LANES-1:0] cond_i = '0;
   logic [IP_W-1:0]  ip_o;
   logic [LANES-1:0] mask_o;
   logic [LANES-1:0] commit_o;
   logic             done_o;
   logic             overflow_o;

   int n_checks = 0;
   int n_fails  = 0;

   logic [IP_W-1:0]  m_ip = '0;
   logic [LANES-1:0] m_mask = '0;
   logic             m_done = 1'b0;
   logic             m_ovf = 1'b0;
   logic [IP_W-1:0]  m_sip [DEPTH];
   logic [LANES-1:0] m_smk [DEPTH];
   int               m_sp = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   lane_div_seq #(
      .LANES       (LANES),
      .IP_W        (IP_W),
      .STACK_DEPTH (DEPTH)
   ) uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .start_ip_i  (start_ip_i),
      .step_i      (step_i),
      .br_i        (br_i),
      .ret_i       (ret_i),
      .br_target_i (br_target_i),
      .cond_i      (cond_i),
      .ip_o        (ip_o),
      .mask_o      (mask_o),
      .commit_o    (commit_o),
      .done_o      (done_o),
      .overflow_o  (overflow_o)
   );

   task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic string tag_of(input logic s, input logic r, input logic b, input logic t,
                                    input logic [LANES-1:0] mk, input logic [LANES-1:0] cd);
      logic [LANES-1:0] tk;
      tk = cd & mk;
      if (s) return "R1";
      if (mk == '0) return "R7";
      if (r) return (m_sp == 0) ? "R7" : "R6";
      if (b) begin
         if (tk == mk) return "R3";
         if (tk == '0) return "R4";
         return (m_sp >= DEPTH) ? "R8" : "R5";
      end
      if (t) return "R2";
      return "R9";
   endfunction

   task automatic model_update();
      logic [LANES-1:0] tk;
      m_done = 1'b0;
      tk = cond_i & m_mask;
      if (start_i) begin
         m_ip = start_ip_i; m_mask = '1; m_sp = 0; m_ovf = 1'b0;
      end else if (m_mask != '0) begin
         if (ret_i) begin
            if (m_sp == 0) begin
               m_done = 1'b1; m_mask = '0;
            end else begin
               m_sp--; m_ip = m_sip[m_sp]; m_mask = m_smk[m_sp];
            end
         end else if (br_i) begin
            if (tk == m_mask) begin
               m_ip = br_target_i;
            end else if (tk == '0) begin
               m_ip = m_ip + 1'b1;
            end else begin
               if (m_sp < DEPTH) begin
                  m_sip[m_sp] = m_ip + 1'b1; m_smk[m_sp] = m_mask & ~tk; m_sp++;
               end else begin
                  m_ovf = 1'b1;
               end
               m_ip = br_target_i; m_mask = tk;
            end
         end else if (step_i) begin
            m_ip = m_ip + 1'b1;
         end
      end
   endtask

   // Called at a falling edge: drive, check commit, clock, check registers.
   task automatic cycle(input logic s, input logic [IP_W-1:0] sip, input logic t, input logic b,
                        input logic r, input logic [IP_W-1:0] tgt, input logic [LANES-1:0] cd);
      string tg;
      logic [LANES-1:0] exp_commit;
      start_i = s; start_ip_i = sip; step_i = t; br_i = b; ret_i = r;
      br_target_i = tgt; cond_i = cd;
      tg = tag_of(s, r, b, t, m_mask, cd);
      #1;
      exp_commit = (!s && (t || b || r)) ? m_mask : '0;
      check("R9", "commit_o", 32'(commit_o), 32'(exp_commit));
      @(posedge clk);
      model_update();
      @(negedge clk);
      check(tg, "ip_o", 32'(ip_o), 32'(m_ip));
      check(tg, "mask_o", 32'(mask_o), 32'(m_mask));
      check(tg, "done_o", 32'(done_o), 32'(m_done));
      check(tg, "overflow_o", 32'(overflow_o), 32'(m_ovf));
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      int seed;
      seed = 32'h5eed_0042;
      void'($urandom(seed));
      repeat (3) @(negedge clk);
      // reset state
      check("R1", "ip_o after reset", 32'(ip_o), 32'h0);
      check("R7", "mask_o after reset", 32'(mask_o), 32'h0);
      check("R7", "done_o after reset", 32'(done_o), 32'h0);
      check("R8", "overflow_o after reset", 32'(overflow_o), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R7: events while idle have no effect
      cycle(0, '0, 1, 0, 0, 16'h0300, 4'hF);
      cycle(0, '0, 0, 1, 0, 16'h0300, 4'hF);
      cycle(0, '0, 0, 0, 1, 16'h0300, 4'h0);

      // R1: load packet
      cycle(1, 16'h0100, 1, 1, 1, 16'h0999, 4'h5);
      // R2: step
      cycle(0, '0, 1, 0, 0, '0, '0);
      // R3: uniform taken, inactive cond ignored later
      cycle(0, '0, 0, 1, 0, 16'h0200, 4'hF);
      // R4: uniform not taken
      cycle(0, '0, 0, 1, 0, 16'h0777, 4'h0);
      // R5 three-deep split; depth 2 forces R8 on third
      cycle(0, '0, 0, 1, 0, 16'h0400, 4'h7);
      cycle(0, '0, 0, 1, 0, 16'h0500, 4'h3);
      // R3 with inactive lanes' cond bits set
      cycle(0, '0, 0, 1, 0, 16'h0520, 4'hB);
      cycle(0, '0, 0, 1, 0, 16'h0600, 4'h1);
      // R10: return beats branch and step
      cycle(0, '0, 1, 1, 1, 16'h0abc, 4'h1);
      cycle(0, '0, 0, 0, 1, '0, '0);
      // R7: final return ends packet
      cycle(0, '0, 0, 0, 1, '0, '0);
      cycle(0, '0, 1, 0, 0, '0, '0);
      // R1: start clears overflow
      cycle(1, 16'h1000, 0, 0, 0, '0, '0);
      // R10: branch beats step
      cycle(0, '0, 1, 1, 0, 16'h2000, 4'hF);

      // random mix
      for (int i = 0; i < 4000; i++) begin
         int r;
         logic s, t, b, rt;
         r  = $urandom_range(99);
         s  = (r < 3);
         rt = (r >= 3 && r < 20);
         b  = (r >= 20 && r < 60);
         t  = (r >= 60 && r < 90) || ($urandom_range(7) == 0);
         cycle(s, 16'($urandom), t, b, rt, 16'($urandom), 4'($urandom));
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule